// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 24-bit virtual address into a 24-bit real address by walking two tables held in storage. The virtual address first selects an entry in a segment table. That entry gives the location and length of a page table. The page part of the address then selects a two-byte page table entry, which supplies the upper bits of the real page frame. The low offset bits pass through unchanged. The page size is chosen at run time between 2K and 4K. It is sampled once per request, so a change made during a walk does not affect that walk.

Requests arrive on a valid/ready interface. Each request is marked implicit (instruction or data fetch) or explicit (a load-real-address style query). Only one walk is in flight at a time. Every storage read is issued on a simple request/response port and is held until its response arrives.

A walk ends with one response pulse that carries either the real address or an exception code. A failed implicit request also raises a program interrupt pulse, which cannot be masked. A failed explicit request reports the same code as a condition code and raises no interrupt. The segment table origin and length are loaded through a small configuration port.

Top module: `seg_page_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_req and prog_irq are 0.
- R2: If the segment index (vaddr[23:16]) is greater than or equal to the configured segment table length, the walk ends with a segment exception and issues no storage read.
- R3: The segment entry is read as one 32-bit word at table origin + 4 × segment index. Its fields are: invalid = bit 0, page table origin = bits [23:3] with three zero bits appended, page table length = bits [31:26]. If the invalid bit is 1, the walk ends with a segment exception after that single read.
- R4: If the page index is greater than or equal to the page table length from the segment entry, the walk ends with a page exception and reads no page entry.
- R5: The page entry is the halfword at page table origin + 2 × page index. It is taken from bits [31:16] of the returned word when address bit 1 is 0, and from bits [15:0] when it is 1. If its invalid bit is 1 (bit 3 for 4K pages, bit 2 for 2K pages), the walk ends with a page exception.
- R6: With 4K pages, the page index is vaddr[15:12] and the real address is {entry[15:4], vaddr[11:0]}. Entry bits [2:0] are ignored.
- R7: With 2K pages, the page index is vaddr[15:11] and the real address is {entry[15:3], vaddr[10:0]}.
- R8: The page size input (1 = 4K, 0 = 2K) is sampled when the request is accepted. A change after acceptance does not alter that walk's result.
- R9: When an implicit request fails, prog_irq pulses together with rsp_valid and rsp_cc stays 0. When an explicit request fails, rsp_cc equals the exception code and prog_irq stays 0. A successful walk gives rsp_cc = 0 and no interrupt.
- R10: req_ready is 0 from the cycle after a request is accepted until the response pulse. mem_req, once raised, stays high with a stable mem_addr until mem_rsp_valid is seen.
- R11: rsp_exc encodes 0 = translated, 1 = segment exception, 2 = page exception. On any exception, rsp_real_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load segment table origin and length |
| cfg_seg_base | input | 24 | Segment table origin (word aligned, low two bits dropped) |
| cfg_seg_len | input | 9 | Number of segment table entries |
| page_4k | input | 1 | Page size select: 1 = 4K, 0 = 2K |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_explicit | input | 1 | 1 = explicit request, 0 = implicit |
| req_vaddr | input | 24 | Virtual address |
| mem_req | output | 1 | Storage read request, held until response |
| mem_addr | output | 24 | Storage byte address of the read |
| mem_rsp_valid | input | 1 | Storage read data valid |
| mem_rsp_data | input | 32 | Word containing the addressed entry |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_real_addr | output | 24 | Translated real address |
| rsp_exc | output | 2 | Exception code |
| rsp_cc | output | 2 | Condition code for explicit requests |
| prog_irq | output | 1 | Program interrupt pulse for failed implicit requests |

## Verification
The hardest case to reach is a page size change that lands in the middle of a walk. The bench accepts a request in one mode, flips page_4k on the very next cycle, and slows the storage responses. The table contents are chosen so that reading the other mode's page entry would either hit an invalid entry or give a different frame. The halfword select and the boundary comparisons also need table contents placed at the right spots. These cases use a page entry in the upper half of a word, a page index one below and exactly at the page table length, a segment index exactly at the segment table length, and the last entry of a full 32-entry page table.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  localparam int VA_W       = 24;
  localparam int SEG_IX_W   = 8;
  localparam int SPAN_W     = VA_W - SEG_IX_W;
  localparam int OFF_4K     = 12;
  localparam int OFF_2K     = 11;
  localparam int PG_W       = SPAN_W - OFF_2K;
  localparam int PG4_W      = SPAN_W - OFF_4K;
  localparam int FRAME_W    = VA_W - OFF_2K;
  localparam int STL_W      = SEG_IX_W + 1;
  localparam int PTL_W      = PG_W + 1;
  localparam int WORD_W     = 32;
  localparam int PTE_W      = 16;
  localparam int PT_ALIGN   = 3;
  localparam int STE_BYTES_LOG = 2;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_SEG  = 2'd1,
    EXC_PAGE = 2'd2
  } exc_e;

  typedef struct packed {
    logic [PTL_W-1:0] pt_len;
    logic [VA_W-1:0]  pt_base;
    logic             invalid;
  } ste_t;
endpackage

// File: rtl/wlk_cfg_regs.sv
module wlk_cfg_regs
  import wlk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [VA_W-1:0]  cfg_base,
  input  logic [STL_W-1:0] cfg_len,
  output logic [VA_W-1:0]  stb_base,
  output logic [STL_W-1:0] stb_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb_base <= '0;
      stb_len  <= '0;
    end else if (cfg_we) begin
      stb_base <= {cfg_base[VA_W-1:STE_BYTES_LOG], {STE_BYTES_LOG{1'b0}}};
      stb_len  <= cfg_len;
    end
  end
endmodule

// File: rtl/wlk_va_split.sv
module wlk_va_split
  import wlk_pkg::*;
(
  input  logic                va,
  input  logic [VA_W-1:0]     vaddr,
  input  logic                mode_4k,
  input  logic [FRAME_W-1:0]  frame,
  output logic [SEG_IX_W-1:0] seg_ix,
  output logic [PG_W-1:0]     page_ix,
  output logic [VA_W-1:0]     real_addr
);
  logic unused_va;
  assign unused_va = va;

  assign seg_ix = vaddr[VA_W-1 -: SEG_IX_W];

  always_comb begin
    if (mode_4k) begin
      page_ix   = {{(PG_W-PG4_W){1'b0}}, vaddr[SPAN_W-1 -: PG4_W]};
      real_addr = {frame[VA_W-OFF_4K-1:0], vaddr[OFF_4K-1:0]};
    end else begin
      page_ix   = vaddr[SPAN_W-1 -: PG_W];
      real_addr = {frame, vaddr[OFF_2K-1:0]};
    end
  end
endmodule

// File: rtl/wlk_entry_dec.sv
module wlk_entry_dec
  import wlk_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic               half_hi,
  input  logic               mode_4k,
  output ste_t               ste,
  output logic [FRAME_W-1:0] pte_frame,
  output logic               pte_inv
);
  localparam int HI_LSB = WORD_W - PTE_W;

  logic [PTE_W-1:0] half;
  logic             unused_bits;

  assign ste.pt_len  = word[WORD_W-1 -: PTL_W];
  assign ste.pt_base = {word[VA_W-1:PT_ALIGN], {PT_ALIGN{1'b0}}};
  assign ste.invalid = word[0];

  assign half = half_hi ? word[WORD_W-1:HI_LSB] : word[PTE_W-1:0];

  always_comb begin
    if (mode_4k) begin
      pte_frame = {1'b0, half[PTE_W-1 -: (VA_W-OFF_4K)]};
      pte_inv   = half[PTE_W-1-(VA_W-OFF_4K)];
    end else begin
      pte_frame = half[PTE_W-1 -: FRAME_W];
      pte_inv   = half[PTE_W-1-FRAME_W];
    end
  end

  assign unused_bits = ^{half[1:0], word[WORD_W-PTL_W-1:VA_W], word[PT_ALIGN-1:1]};
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
  import wlk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [VA_W-1:0]      cfg_seg_base,
  input  logic [STL_W-1:0]     cfg_seg_len,
  input  logic                 page_4k,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_explicit,
  input  logic [VA_W-1:0]      req_vaddr,
  output logic                 mem_req,
  output logic [VA_W-1:0]      mem_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 rsp_valid,
  output logic [VA_W-1:0]      rsp_real_addr,
  output logic [1:0]           rsp_exc,
  output logic [1:0]           rsp_cc,
  output logic                 prog_irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_STE, ST_PTE} st_e;

  st_e                 state;
  logic [VA_W-1:0]     lat_va;
  logic                lat_expl;
  logic                lat_4k;
  logic [VA_W-1:0]     stb_base;
  logic [STL_W-1:0]    stb_len;
  logic [SEG_IX_W-1:0] seg_ix;
  logic [PG_W-1:0]     page_ix;
  logic [VA_W-1:0]     comp_real;
  ste_t                ste;
  logic [FRAME_W-1:0]  pte_frame;
  logic                pte_inv;
  logic                seg_over;
  logic                pg_over;
  logic [VA_W-1:0]     ste_addr;
  logic [VA_W-1:0]     pte_addr;
  logic                fin_go;
  exc_e                fin_code;
  logic [VA_W-1:0]     fin_real;

  wlk_cfg_regs u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_base (cfg_seg_base),
    .cfg_len  (cfg_seg_len),
    .stb_base (stb_base),
    .stb_len  (stb_len)
  );

  wlk_va_split u_split (
    .va        (lat_expl),
    .vaddr     (lat_va),
    .mode_4k   (lat_4k),
    .frame     (pte_frame),
    .seg_ix    (seg_ix),
    .page_ix   (page_ix),
    .real_addr (comp_real)
  );

  wlk_entry_dec u_dec (
    .word      (mem_rsp_data),
    .half_hi   (~mem_addr[1]),
    .mode_4k   (lat_4k),
    .ste       (ste),
    .pte_frame (pte_frame),
    .pte_inv   (pte_inv)
  );

  assign req_ready = (state == ST_IDLE);
  assign seg_over  = {1'b0, seg_ix} >= stb_len;
  assign pg_over   = {1'b0, page_ix} >= ste.pt_len;
  assign ste_addr  = stb_base + {{(VA_W-SEG_IX_W-STE_BYTES_LOG){1'b0}}, seg_ix, {STE_BYTES_LOG{1'b0}}};
  assign pte_addr  = ste.pt_base + {{(VA_W-PG_W-1){1'b0}}, page_ix, 1'b0};

  always_comb begin
    fin_go   = 1'b0;
    fin_code = EXC_NONE;
    fin_real = '0;
    case (state)
      ST_CHK: begin
        if (seg_over) begin
          fin_go   = 1'b1;
          fin_code = EXC_SEG;
        end
      end
      ST_STE: begin
        if (mem_rsp_valid) begin
          if (ste.invalid) begin
            fin_go   = 1'b1;
            fin_code = EXC_SEG;
          end else if (pg_over) begin
            fin_go   = 1'b1;
            fin_code = EXC_PAGE;
          end
        end
      end
      ST_PTE: begin
        if (mem_rsp_valid) begin
          fin_go = 1'b1;
          if (pte_inv) fin_code = EXC_PAGE;
          else         fin_real = comp_real;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      lat_va        <= '0;
      lat_expl      <= 1'b0;
      lat_4k        <= 1'b0;
      mem_req       <= 1'b0;
      mem_addr      <= '0;
      rsp_valid     <= 1'b0;
      rsp_real_addr <= '0;
      rsp_exc       <= EXC_NONE;
      rsp_cc        <= EXC_NONE;
      prog_irq      <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      prog_irq  <= 1'b0;
      if (fin_go) begin
        rsp_valid     <= 1'b1;
        rsp_exc       <= fin_code;
        rsp_cc        <= lat_expl ? fin_code : EXC_NONE;
        prog_irq      <= ~lat_expl && (fin_code != EXC_NONE);
        rsp_real_addr <= fin_real;
        mem_req       <= 1'b0;
        state         <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (req_valid) begin
              lat_va   <= req_vaddr;
              lat_expl <= req_explicit;
              lat_4k   <= page_4k;
              state    <= ST_CHK;
            end
          end
          ST_CHK: begin
            mem_req  <= 1'b1;
            mem_addr <= ste_addr;
            state    <= ST_STE;
          end
          ST_STE: begin
            if (mem_rsp_valid) begin
              mem_addr <= pte_addr;
              state    <= ST_PTE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: a pending read keeps its request and address
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

  // R10: no acceptance while a read is pending
  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R2: segment overflow never reaches storage
  a_r2_no_read: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHK && seg_over) |=> !mem_req);

  // R9: interrupt only with a failing implicit response
  a_r9_irq_implicit: assert property (@(posedge clk) disable iff (rst)
    prog_irq |-> (rsp_valid && rsp_exc != 2'd0 && rsp_cc == 2'd0));

  // R9: a nonzero condition code never comes with an interrupt
  a_r9_cc_no_irq: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cc != 2'd0) |-> (!prog_irq && rsp_cc == rsp_exc));

  // R11: only legal codes, and no address on a fault
  a_r11_code_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_exc != 2'd3 && (rsp_exc == 2'd0 || rsp_real_addr == '0)));
endmodule

// File: tb/tb_seg_page_walker.sv
`timescale 1ns/1ps
module tb_seg_page_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [23:0] cfg_seg_base = '0;
  logic [8:0]  cfg_seg_len = '0;
  logic        page_4k = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_explicit = 1'b0;
  logic [23:0] req_vaddr = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [23:0] rsp_real_addr;
  logic [1:0]  rsp_exc;
  logic [1:0]  rsp_cc;
  logic        prog_irq;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wcnt = 0;
  int rd_count = 0;
  logic [23:0] rd_log [0:3];
  logic [31:0] bmem [0:1023];

  seg_page_walker dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_seg_base(cfg_seg_base),
    .cfg_seg_len(cfg_seg_len), .page_4k(page_4k), .req_valid(req_valid),
    .req_ready(req_ready), .req_explicit(req_explicit), .req_vaddr(req_vaddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_real_addr(rsp_real_addr), .rsp_exc(rsp_exc), .rsp_cc(rsp_cc),
    .prog_irq(prog_irq)
  );

  always #10 clk = ~clk;

  // storage model: answers a held read after lat falling edges
  always @(negedge clk) begin
    if (rst) begin
      mem_rsp_valid = 1'b0;
      wcnt = 0;
    end else if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = bmem[mem_addr[11:2]];
        if (rd_count < 4) rd_log[rd_count] = mem_addr;
        rd_count++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ste(input int len, input logic [23:0] base, input logic inv);
    logic [5:0] l6;
    l6 = len[5:0];
    return {l6, 2'b00, base[23:3], 2'b00, inv};
  endfunction

  task automatic set_half(input logic [23:0] a, input logic [15:0] v);
    if (a[1] == 1'b0) bmem[a[11:2]][31:16] = v;
    else              bmem[a[11:2]][15:0]  = v;
  endtask

  // one walk; outputs sampled at the falling edge where rsp_valid is seen
  task automatic run(input string rq, input logic expl, input logic [23:0] va,
                     input logic mode, input logic flip, input int latency,
                     input logic [1:0] exp_exc, input logic [23:0] exp_real,
                     input int exp_reads, input logic [23:0] exp_first);
    int n;
    lat = latency;
    @(negedge clk);
    rd_count = 0;
    req_valid = 1'b1;
    req_explicit = expl;
    req_vaddr = va;
    page_4k = mode;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) page_4k = ~mode;
    check({rq, " R10 ready low while busy"}, {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({rq, " response seen"}, {31'd0, rsp_valid}, 32'd1);
    check({rq, " R11 code"}, {30'd0, rsp_exc}, {30'd0, exp_exc});
    check({rq, " R9 cc"}, {30'd0, rsp_cc}, expl ? {30'd0, exp_exc} : 32'd0);
    check({rq, " R9 irq"}, {31'd0, prog_irq}, {31'd0, (!expl && exp_exc != 2'd0)});
    check({rq, " real address"}, {8'd0, rsp_real_addr}, {8'd0, exp_real});
    check({rq, " read count"}, rd_count, exp_reads);
    if (exp_reads > 0) check({rq, " R3 segment entry address"}, {8'd0, rd_log[0]}, {8'd0, exp_first});
    check({rq, " R10 ready after response"}, {31'd0, req_ready}, 32'd1);
    page_4k = mode;
  endtask

  task automatic t_reset;
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 prog_irq", {31'd0, prog_irq}, 32'd0);
  endtask

  task automatic t_seg_over;
    run("R2 seg 5 implicit", 1'b0, 24'h05_1234, 1'b1, 1'b0, 0, 2'd1, 24'h0, 0, 24'h0);
    run("R2 seg 4 = len explicit", 1'b1, 24'h04_0000, 1'b1, 1'b0, 1, 2'd1, 24'h0, 0, 24'h0);
  endtask

  task automatic t_ste_invalid;
    run("R3 invalid segment implicit", 1'b0, 24'h01_5123, 1'b1, 1'b0, 2, 2'd1, 24'h0, 1, 24'h000104);
    run("R3 invalid segment explicit", 1'b1, 24'h01_0000, 1'b0, 1'b0, 0, 2'd1, 24'h0, 1, 24'h000104);
  endtask

  task automatic t_page_len;
    run("R4 page = length", 1'b1, 24'h03_2000, 1'b1, 1'b0, 1, 2'd2, 24'h0, 1, 24'h00010C);
    run("R4 page below length", 1'b0, 24'h03_1456, 1'b1, 1'b0, 0, 2'd0, {12'h777, 12'h456}, 2, 24'h00010C);
    check("R5 page entry address low half", {8'd0, rd_log[1]}, 32'h402);
  endtask

  task automatic t_4k;
    run("R6 4K lower half", 1'b0, 24'h00_5123, 1'b1, 1'b0, 3, 2'd0, {12'hABC, 12'h123}, 2, 24'h000100);
    check("R5 entry address 0x20A", {8'd0, rd_log[1]}, 32'h20A);
    run("R5 4K upper half", 1'b1, 24'h00_4FFF, 1'b1, 1'b0, 0, 2'd0, {12'h123, 12'hFFF}, 2, 24'h000100);
    check("R5 entry address 0x208", {8'd0, rd_log[1]}, 32'h208);
  endtask

  task automatic t_pte_invalid;
    run("R5 invalid page implicit", 1'b0, 24'h00_6000, 1'b1, 1'b0, 1, 2'd2, 24'h0, 2, 24'h000100);
    run("R5 invalid page explicit", 1'b1, 24'h00_6ABC, 1'b1, 1'b0, 0, 2'd2, 24'h0, 2, 24'h000100);
  endtask

  task automatic t_2k;
    run("R7 2K page 17", 1'b0, 24'h02_8AAB, 1'b0, 1'b0, 2, 2'd0, {13'h1A5B, 11'h2AB}, 2, 24'h000108);
    check("R7 entry address 0x322", {8'd0, rd_log[1]}, 32'h322);
    run("R7 2K last page", 1'b1, 24'h02_FFFF, 1'b0, 1'b0, 0, 2'd0, {13'h1FFF, 11'h7FF}, 2, 24'h000108);
  endtask

  task automatic t_mode_sample;
    run("R8 4K held after flip", 1'b0, 24'h00_5123, 1'b1, 1'b1, 3, 2'd0, {12'hABC, 12'h123}, 2, 24'h000100);
    run("R8 2K held after flip", 1'b0, 24'h02_8AAB, 1'b0, 1'b1, 3, 2'd0, {13'h1A5B, 11'h2AB}, 2, 24'h000108);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'h0;
    bmem[24'h100 >> 2] = mk_ste(16, 24'h000200, 1'b0);
    bmem[24'h104 >> 2] = mk_ste(16, 24'h000200, 1'b1);
    bmem[24'h108 >> 2] = mk_ste(32, 24'h000300, 1'b0);
    bmem[24'h10C >> 2] = mk_ste(2,  24'h000400, 1'b0);
    set_half(24'h208, {12'h123, 1'b0, 3'b000});
    set_half(24'h20A, {12'hABC, 1'b0, 3'b101});
    set_half(24'h20C, {12'hFFF, 1'b1, 3'b000});
    set_half(24'h214, {13'h0AAA, 1'b1, 2'b00});
    set_half(24'h322, {13'h1A5B, 1'b0, 2'b11});
    set_half(24'h33E, {13'h1FFF, 1'b0, 2'b00});
    set_half(24'h310, {12'h555, 1'b1, 3'b000});
    set_half(24'h402, {12'h777, 1'b0, 3'b000});

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_we = 1'b1;
    cfg_seg_base = 24'h000100;
    cfg_seg_len = 9'd4;
    @(negedge clk);
    cfg_we = 1'b0;

    t_seg_over();
    t_ste_invalid();
    t_page_len();
    t_4k();
    t_pte_invalid();
    t_2k();
    t_mode_sample();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule